// File: doc/BRIEF.md
# Multi-format serial audio receiver

The receiver takes stereo two's-complement audio from a single serial data line. A frame clock marks the two halves of each sample frame. Every pin is sampled in the master clock domain. The bit clock that moves data into the block has two sources. In external mode it is a pin, and the block detects its rising edges. In internal mode the master clock is divided down. The divisor comes from the master-to-frame clock ratio code and the selected data format. Four layouts are supported: I2S, left-justified, right-justified 24-bit and right-justified 16-bit.

Each complete frame gives one left/right pair of 24-bit samples on a valid/ready output. Audio cannot pause, so the block never stalls its input. A pair stays presented, with `out_valid` high, until `out_ready` is seen high on a clock edge. If the pair has not been taken when the next frame completes, the newer pair replaces it.

Top module: `audio_frame_rx`

## Requirements
- R1: While `rst_n` is low and on the first edge after it rises, `out_valid` is 0 and both sample outputs are 0.
- R2: Serial data is taken on the rising edges of the bit clock, MSB first, and read as two's complement.
- R3: In internal mode one bit lasts ratio/bits-per-frame master clock cycles. `ratio_sel` codes 0..9 mean ratios 64, 96, 128, 192, 256, 384, 512, 768, 1024 and 1152; codes 10..15 act as 256. Bits per frame are 72 at ratio 1152 and 48 at 96/192/384/768. At 64/128/256/512/1024 they are 32 for I2S and right-justified 16-bit, and 64 for the other two formats.
- R4: Every transition of `frame_clk` restarts the internal bit timing and the bit slot count, so slot 0 begins at the transition.
- R5: I2S (`fmt_sel`=0): the MSB is in slot 1 after the transition and the left channel travels while `frame_clk` is low. At most 24 bits are kept. A word that fills its half ends in slot 0 of the next half.
- R6: Left-justified (`fmt_sel`=1): the MSB is in slot 0 and the left channel travels while `frame_clk` is high. At most 24 bits are kept.
- R7: In I2S and left-justified, a word shorter than 24 bits is left-aligned and its unused low bits read as 0.
- R8: Right-justified 24-bit (`fmt_sel`=2): the sample is the last 24 bits before the `frame_clk` transition. The left channel travels while `frame_clk` is high.
- R9: Right-justified 16-bit (`fmt_sel`=3): the sample is the last 16 bits before the transition, sign-extended to 24 bits. Channels are as in R8.
- R10: One strobe per frame. Both outputs update together when the right word completes, and the left word is held until then.
- R11: `out_valid` stays high until an edge with `out_ready` high. A newer pair overwrites one that has not been accepted.
- R12: With `ext_sel`=1, the rising edges of `bit_clk_ext` clock the data, and a half frame may hold any number of bits; `ratio_sel` is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Frame clock marking the channel halves |
| ser_data | input | 1 | Serial audio data |
| bit_clk_ext | input | 1 | External bit clock, used when `ext_sel` is 1 |
| ext_sel | input | 1 | 1 = external bit clock, 0 = internal divider |
| fmt_sel | input | 2 | 0 I2S, 1 left-justified, 2 right-justified 24, 3 right-justified 16 |
| ratio_sel | input | 4 | Master-to-frame clock ratio code (R3) |
| out_ready | input | 1 | Consumer accepts the presented pair |
| out_valid | output | 1 | A sample pair is presented |
| out_left | output | 24 | Left sample |
| out_right | output | 24 | Right sample |

## Verification
Each pin passes one register before any logic sees it. A left-justified or right-justified pair therefore appears on `out_valid` two master cycles after the `frame_clk` transition that ends the right half. An I2S pair appears two cycles after the slot-0 bit of the following half has been sampled, which is at most one bit period after the transition. All of these results land well inside the next frame. The bench therefore captures strobes with a monitor on the falling edge and compares the captured pair only after a whole further frame has been sent. Strobe counts are sampled at frame boundaries. Back-pressure is checked on the falling edges right after one frame and right after the single ready cycle.

// File: rtl/afr_pkg.sv
package afr_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ24 = 2'd2,
    FMT_RJ16 = 2'd3
  } fmt_e;

  // Master clock cycles per bit in internal mode: ratio / bits-per-frame.
  // narrow = formats that use 32 bits per frame at the power-of-two ratios.
  function automatic logic [5:0] bit_period(input fmt_e f, input logic [3:0] code);
    logic narrow;
    narrow = (f == FMT_I2S) || (f == FMT_RJ16);
    case (code)
      4'd0:    bit_period = narrow ? 6'd2  : 6'd1;   // 64
      4'd1:    bit_period = 6'd2;                    // 96   / 48
      4'd2:    bit_period = narrow ? 6'd4  : 6'd2;   // 128
      4'd3:    bit_period = 6'd4;                    // 192  / 48
      4'd5:    bit_period = 6'd8;                    // 384  / 48
      4'd6:    bit_period = narrow ? 6'd16 : 6'd8;   // 512
      4'd7:    bit_period = 6'd16;                   // 768  / 48
      4'd8:    bit_period = narrow ? 6'd32 : 6'd16;  // 1024
      4'd9:    bit_period = 6'd16;                   // 1152 / 72
      default: bit_period = narrow ? 6'd8  : 6'd4;   // 256
    endcase
  endfunction

endpackage

// File: rtl/afr_input_stage.sv
module afr_input_stage (
  input  logic mclk,
  input  logic rst_n,
  input  logic frame_clk,
  input  logic ser_data,
  input  logic bit_clk_ext,
  output logic frame_lvl,
  output logic frame_lvl_prev,
  output logic frame_edge,
  output logic data_bit,
  output logic ext_rise
);
  logic bclk_d, bclk_q;

  // One register on every pin keeps frame clock, data and bit clock aligned.
  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      frame_lvl      <= 1'b0;
      frame_lvl_prev <= 1'b0;
      data_bit       <= 1'b0;
      bclk_d         <= 1'b0;
      bclk_q         <= 1'b0;
    end else begin
      frame_lvl      <= frame_clk;
      frame_lvl_prev <= frame_lvl;
      data_bit       <= ser_data;
      bclk_d         <= bit_clk_ext;
      bclk_q         <= bclk_d;
    end
  end

  assign frame_edge = frame_lvl ^ frame_lvl_prev;
  assign ext_rise   = bclk_d & ~bclk_q;
endmodule

// File: rtl/afr_bit_timer.sv
module afr_bit_timer
  import afr_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int DIV_W  = 6
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              ext_sel,
  input  fmt_e              fmt,
  input  logic [3:0]        ratio_sel,
  input  logic              frame_edge,
  input  logic              ext_rise,
  output logic              bit_tick,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] SLOT_TOP = {SLOT_W{1'b1}};

  logic [DIV_W-1:0]  period, phase, phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic              int_tick;

  assign period   = DIV_W'(bit_period(fmt, ratio_sel));
  assign phase    = frame_edge ? '0 : phase_q;
  assign int_tick = (phase == period - DIV_W'(1));
  assign bit_tick = ext_sel ? ext_rise : int_tick;
  assign slot     = frame_edge ? '0 : slot_q;

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      phase_q <= '0;
      slot_q  <= '0;
    end else begin
      phase_q <= int_tick ? '0 : phase + DIV_W'(1);
      if (bit_tick && slot != SLOT_TOP) slot_q <= slot + SLOT_W'(1);
      else                              slot_q <= slot;
    end
  end
endmodule

// File: rtl/afr_word_builder.sv
module afr_word_builder
  import afr_pkg::*;
#(
  parameter int W      = 24,
  parameter int NARROW = 16,
  parameter int SLOT_W = 8
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic              bit_tick,
  input  logic [SLOT_W-1:0] slot,
  input  logic              data_bit,
  input  logic              frame_edge,
  input  logic              frame_lvl,
  input  logic              frame_lvl_prev,
  output logic              word_done,
  output logic              word_left,
  output logic [W-1:0]      word
);
  localparam int KW = $clog2(W + 1);
  localparam logic [KW-1:0] KMAX = KW'(W);

  logic [W-1:0]  sh_q, sh_n;
  logic [KW-1:0] k_q, k_base, k_n;
  logic          edge_done, i2s_done, take, shift;

  function automatic logic [W-1:0] justify(input logic [W-1:0] s, input logic [KW-1:0] k);
    if (k == '0) return '0;
    return s << (W - int'(k));
  endfunction

  // Justified formats close a word at the frame edge; I2S after slot 0.
  assign edge_done = frame_edge && (fmt != FMT_I2S);
  assign k_base    = edge_done ? '0 : k_q;

  always_comb begin
    case (fmt)
      FMT_I2S: take = (k_base < KMAX);
      FMT_LJ:  take = (slot < SLOT_W'(W)) && (k_base < KMAX);
      default: take = 1'b1;
    endcase
  end

  assign shift    = bit_tick && take;
  assign sh_n     = shift ? {sh_q[W-2:0], data_bit} : sh_q;
  assign k_n      = (shift && k_base < KMAX) ? k_base + KW'(1) : k_base;
  assign i2s_done = (fmt == FMT_I2S) && bit_tick && (slot == '0);
  assign word_done = edge_done || i2s_done;

  always_comb begin
    if (i2s_done) begin
      word      = justify(sh_n, k_n);
      word_left = frame_lvl;          // finished half was low when level is now high
    end else begin
      word_left = frame_lvl_prev;     // finished half was high
      case (fmt)
        FMT_LJ:   word = justify(sh_q, k_q);
        FMT_RJ16: word = {{(W-NARROW){sh_q[NARROW-1]}}, sh_q[NARROW-1:0]};
        default:  word = sh_q;
      endcase
    end
  end

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      sh_q <= '0;
      k_q  <= '0;
    end else begin
      sh_q <= sh_n;
      k_q  <= i2s_done ? '0 : k_n;
    end
  end
endmodule

// File: rtl/audio_frame_rx.sv
module audio_frame_rx
  import afr_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16,
  parameter int SLOT_W   = 8,
  parameter int DIV_W    = 6
) (
  input  logic                mclk,
  input  logic                rst_n,
  input  logic                frame_clk,
  input  logic                ser_data,
  input  logic                bit_clk_ext,
  input  logic                ext_sel,
  input  logic [1:0]          fmt_sel,
  input  logic [3:0]          ratio_sel,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  fmt_e                fmt;
  logic                frame_lvl, frame_lvl_prev, frame_edge, data_bit, ext_rise;
  logic                bit_tick, word_done, word_left;
  logic [SLOT_W-1:0]   slot;
  logic [SAMPLE_W-1:0] word, hold_left;

  assign fmt = fmt_e'(fmt_sel);

  afr_input_stage u_in (
    .mclk(mclk), .rst_n(rst_n), .frame_clk(frame_clk), .ser_data(ser_data),
    .bit_clk_ext(bit_clk_ext), .frame_lvl(frame_lvl), .frame_lvl_prev(frame_lvl_prev),
    .frame_edge(frame_edge), .data_bit(data_bit), .ext_rise(ext_rise)
  );

  afr_bit_timer #(.SLOT_W(SLOT_W), .DIV_W(DIV_W)) u_timer (
    .mclk(mclk), .rst_n(rst_n), .ext_sel(ext_sel), .fmt(fmt), .ratio_sel(ratio_sel),
    .frame_edge(frame_edge), .ext_rise(ext_rise), .bit_tick(bit_tick), .slot(slot)
  );

  afr_word_builder #(.W(SAMPLE_W), .NARROW(NARROW_W), .SLOT_W(SLOT_W)) u_word (
    .mclk(mclk), .rst_n(rst_n), .fmt(fmt), .bit_tick(bit_tick), .slot(slot),
    .data_bit(data_bit), .frame_edge(frame_edge), .frame_lvl(frame_lvl),
    .frame_lvl_prev(frame_lvl_prev), .word_done(word_done), .word_left(word_left),
    .word(word)
  );

  // Output stage: left waits for right; no stall, newer pair wins.
  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      hold_left <= '0;
      out_left  <= '0;
      out_right <= '0;
      out_valid <= 1'b0;
    end else begin
      if (word_done && word_left) hold_left <= word;
      if (word_done && !word_left) begin
        out_left  <= hold_left;
        out_right <= word;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_frame_rx_chk.sv
module audio_frame_rx_chk (
  input logic        mclk,
  input logic        rst_n,
  input logic        ext_sel,
  input logic [1:0]  fmt_sel,
  input logic [3:0]  ratio_sel,
  input logic        out_ready,
  input logic        out_valid,
  input logic [23:0] out_left,
  input logic [23:0] out_right,
  input logic        bit_tick,
  input logic        right_done
);
  p_reset_clear_r1: assert property (@(posedge mclk) disable iff (!rst_n)
    (!$past(rst_n)) |-> (!out_valid && out_left == 24'd0 && out_right == 24'd0));

  // Back-to-back internal ticks only when one bit lasts one cycle (R3).
  p_fast_tick_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    (!ext_sel && !$past(ext_sel) && bit_tick && $past(bit_tick)
     && $stable(fmt_sel) && $stable(ratio_sel))
    |-> (ratio_sel == 4'd0 && (fmt_sel == 2'd1 || fmt_sel == 2'd2)));

  p_sign_fill_r9: assert property (@(posedge mclk) disable iff (!rst_n)
    ($rose(out_valid) && fmt_sel == 2'd3 && $past(fmt_sel) == 2'd3)
    |-> (out_right[23:16] == {8{out_right[15]}}));

  p_strobe_source_r10: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(right_done));

  p_hold_r11: assert property (@(posedge mclk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  p_release_r11: assert property (@(posedge mclk) disable iff (!rst_n)
    (out_valid && out_ready && !right_done) |=> !out_valid);
endmodule

bind audio_frame_rx audio_frame_rx_chk i_chk (
  .mclk(mclk), .rst_n(rst_n), .ext_sel(ext_sel), .fmt_sel(fmt_sel),
  .ratio_sel(ratio_sel), .out_ready(out_ready), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right), .bit_tick(bit_tick),
  .right_done(word_done & ~word_left)
);

// File: tb/test_audio_frame_rx.sv
`timescale 1ns/1ps
module test_audio_frame_rx;
  logic        mclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_clk = 1'b0, ser_data = 1'b0, bit_clk_ext = 1'b0, ext_sel = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic [3:0]  ratio_sel = 4'd4;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  int checks = 0, errors = 0, strobes = 0;
  logic [23:0] cap_l = 24'd0, cap_r = 24'd0;
  bit done = 0;

  always #4 mclk = ~mclk;  // 125 MHz

  audio_frame_rx i_audio_frame_rx (
    .mclk(mclk), .rst_n(rst_n), .frame_clk(frame_clk), .ser_data(ser_data),
    .bit_clk_ext(bit_clk_ext), .ext_sel(ext_sel), .fmt_sel(fmt_sel),
    .ratio_sel(ratio_sel), .out_ready(out_ready), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  // Accepted pairs, seen away from the active edge.
  always @(negedge mclk) begin
    if (rst_n && out_valid && out_ready) begin
      cap_l   = out_left;
      cap_r   = out_right;
      strobes = strobes + 1;
    end
  end

  // {ext, fmt, ratio code, left, right}; external half length = 16 + 4*code bits
  localparam int NV = 13;
  localparam logic [54:0] VEC [NV] = '{
    {1'b0, 2'd0, 4'd4, 24'hA5C3F1, 24'h123456},
    {1'b0, 2'd0, 4'd7, 24'h800001, 24'h7FFFFE},
    {1'b0, 2'd0, 4'd9, 24'h3C3C3C, 24'hC0FFEE},
    {1'b0, 2'd1, 4'd0, 24'h9ABCDE, 24'h13579B},
    {1'b0, 2'd1, 4'd1, 24'hFEDCBA, 24'h010203},
    {1'b0, 2'd1, 4'd8, 24'h5A5A5A, 24'hA0A0A1},
    {1'b0, 2'd2, 4'd2, 24'h876543, 24'h00FF00},
    {1'b0, 2'd2, 4'd5, 24'h7FFFFF, 24'h800000},
    {1'b0, 2'd3, 4'd6, 24'h118001, 24'h227FFF},
    {1'b0, 2'd3, 4'd3, 24'h33C000, 24'h4400F0},
    {1'b1, 2'd1, 4'd4, 24'hBEEF01, 24'h2468AC},
    {1'b1, 2'd3, 4'd1, 24'h00ABCD, 24'hFF1234},
    {1'b1, 2'd0, 4'd2, 24'h6D6D6D, 24'h9249A5}
  };

  function automatic int ratio_of(input logic [3:0] c);
    case (c)
      4'd0: return 64;   4'd1: return 96;   4'd2: return 128;  4'd3: return 192;
      4'd5: return 384;  4'd6: return 512;  4'd7: return 768;  4'd8: return 1024;
      4'd9: return 1152; default: return 256;
    endcase
  endfunction

  function automatic int frame_bits(input logic [1:0] f, input logic [3:0] c);
    int r = ratio_of(c);
    if (r == 1152) return 72;
    if (r % 3 == 0) return 48;
    return (f == 2'd0 || f == 2'd3) ? 32 : 64;
  endfunction

  function automatic logic slot_bit(input logic [1:0] f, input logic [23:0] w,
                                    input logic [23:0] p, input int s, input int h);
    int l = (h < 24) ? h : 24;
    int e = h - 1 - s;
    case (f)
      2'd0: begin
        if (s == 0) return (h - 1 < l) ? p[23-(h-1)] : 1'b0;
        return (s - 1 < l) ? w[23-(s-1)] : 1'b0;
      end
      2'd1: return (s < l) ? w[23-s] : 1'b0;
      2'd2: return (e < 24) ? w[e] : 1'b0;
      default: return (e < 16) ? w[e] : 1'b0;
    endcase
  endfunction

  function automatic logic [23:0] expect_word(input logic [1:0] f, input logic [23:0] w, input int h);
    int l = (h < 24) ? h : 24;
    case (f)
      2'd0, 2'd1: return (w >> (24 - l)) << (24 - l);
      2'd2: return w;
      default: return {{8{w[15]}}, w[15:0]};
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic send_half(input logic lvl, input logic [23:0] w, input logic [23:0] p,
                           input logic [1:0] f, input int h, input int n, input logic ext);
    for (int s = 0; s < h; s++) begin
      frame_clk = lvl;
      ser_data  = slot_bit(f, w, p, s, h);
      if (!ext) repeat (n) @(negedge mclk);
      else begin
        bit_clk_ext = 1'b0;
        repeat (2) @(negedge mclk);
        bit_clk_ext = 1'b1;
        repeat (2) @(negedge mclk);
      end
    end
  endtask

  task automatic send_frame(input logic ext, input logic [1:0] f, input int h, input int n,
                            input logic [23:0] wl, input logic [23:0] wr);
    if (f == 2'd0) begin
      send_half(1'b0, wl, wr, f, h, n, ext);
      send_half(1'b1, wr, wl, f, h, n, ext);
    end else begin
      send_half(1'b1, wl, wr, f, h, n, ext);
      send_half(1'b0, wr, wl, f, h, n, ext);
    end
  endtask

  initial begin
    repeat (200000) @(posedge mclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge mclk);
    chk(!out_valid && out_left == 0 && out_right == 0, "R1 during reset",
        {out_left, out_right}, 48'd0);
    rst_n = 1'b1;
    @(negedge mclk);
    chk(!out_valid && out_left == 0 && out_right == 0, "R1 after reset",
        {out_left, out_right}, 48'd0);

    for (int v = 0; v < NV; v++) begin
      logic        ext  = VEC[v][54];
      logic [1:0]  f    = VEC[v][53:52];
      logic [3:0]  c    = VEC[v][51:48];
      logic [23:0] wl   = VEC[v][47:24];
      logic [23:0] wr   = VEC[v][23:0];
      int          h    = ext ? 16 + 4 * int'(c) : frame_bits(f, c) / 2;
      int          n    = ratio_of(c) / frame_bits(f, c);
      int          s2;
      logic [23:0] el   = expect_word(f, wl, h);
      logic [23:0] er   = expect_word(f, wr, h);
      string       tag;
      case (f)
        2'd0: tag = "R5";  2'd1: tag = "R6";  2'd2: tag = "R8";  default: tag = "R9";
      endcase
      tag = ext ? {tag, "/R12/R2"} : {tag, "/R3/R4/R2"};
      ext_sel = ext; fmt_sel = f; ratio_sel = c;
      send_frame(ext, f, h, n, wl, wr);
      send_frame(ext, f, h, n, wl, wr);
      s2 = strobes;
      send_frame(ext, f, h, n, wl, wr);
      chk({cap_l, cap_r} == {el, er}, $sformatf("%s vector %0d pair", tag, v),
          {cap_l, cap_r}, {el, er});
      chk(strobes - s2 == 1, $sformatf("R10 vector %0d strobes per frame", v),
          48'(strobes - s2), 48'd1);
      if (v == 0)  // 16-bit I2S half: low 8 bits zero-filled
        chk(cap_l[7:0] == 8'd0 && cap_r[7:0] == 8'd0, "R7 zero fill",
            {cap_l, cap_r}, {el, er});
    end

    // Back-pressure: unaccepted pair is held, then replaced by the newer one.
    ext_sel = 1'b0; fmt_sel = 2'd1; ratio_sel = 4'd4;
    out_ready = 1'b0;
    send_frame(1'b0, 2'd1, 32, 4, 24'h111111, 24'h222222);
    send_frame(1'b0, 2'd1, 32, 4, 24'hABC123, 24'h456DEF);
    send_frame(1'b0, 2'd1, 32, 4, 24'hABC123, 24'h456DEF);
    chk(out_valid, "R11 valid held without ready", 48'(out_valid), 48'd1);
    chk({out_left, out_right} == {24'hABC123, 24'h456DEF}, "R11 newer pair overwrites",
        {out_left, out_right}, {24'hABC123, 24'h456DEF});
    out_ready = 1'b1;
    @(negedge mclk);
    chk(!out_valid, "R11 valid drops after ready", 48'(out_valid), 48'd0);

    // Reset mid-stream clears outputs.
    rst_n = 1'b0;
    @(negedge mclk);
    rst_n = 1'b1;
    @(negedge mclk);
    chk(!out_valid && out_left == 0 && out_right == 0, "R1 re-reset",
        {out_left, out_right}, 48'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule